// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Comparator Vector

This block decides when a small 8-bit core must leave its program flow and where it must go. A few directly vectored event sources each have their own pending flag and their own vector. Three timer-comparator match events (called P, A and B here) share one multi-function vector. Each of the three has a request flag and an enable bit in a byte-wide control register. A group pending bit is armed whenever the set of enabled, pending comparator flags goes from empty to non-empty. A fixed priority picks one pending source. Direct source 0 comes first, then the other direct sources in index order, and the shared comparator vector comes last.

When the global enable is set and something is pending, the block takes the interrupt. It raises a push strobe carrying the core's current program counter, loads the chosen vector as the new program counter, and clears the global enable so that handlers do not nest. Events that arrive in the meantime are still recorded. A return-from-interrupt input pops the stacked program counter back into the core and sets the global enable again. Software reaches the comparator flags, their enables and the global enable through a byte read/write port with a one-bit address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_cmp_i[k]` (bit 0 = P, bit 1 = A, bit 2 = B) sets that comparator flag. The flag appears in register 0 at bit 4 (P), bit 5 (A) or bit 6 (B). A read strobe returns the register on `reg_rdata_o` one cycle later.
- R2: The enables for P, A and B sit in register 0 at bits 0, 1 and 2. Bits 7 and 3 always read 0. Register 1 holds the global enable in bit 0 and reads 0 in bits 7..1. All of these reset to 0.
- R3: A comparator flag whose enable bit is 0 stays latched but never causes a vector jump. Setting its enable later does cause one.
- R4: While the global enable is 0, no source is taken, whatever the individual flags and enables are.
- R5: Direct source i is flagged in the cycle after its event pulse. In the cycle after that, `push_o` and `pc_load_o` are both high, `push_pc_o` equals the value `pc_i` had in the deciding cycle, and `pc_load_addr_o` equals VEC_BASE + i*VEC_STEP. A group take works the same way and uses VEC_BASE + N_DIR*VEC_STEP (0x004, 0x008 and 0x00C by default).
- R6: Taking an interrupt clears the global enable, so two takes never come in consecutive cycles. Events that arrive while the global enable is 0 are still latched and are serviced after re-enabling.
- R7: When several sources are pending, direct source 0 is taken first, then the higher-indexed direct sources, and the shared comparator vector last.
- R8: Taking the shared vector clears only the group pending bit; the comparator flags keep their values. The group can be taken again only after the enabled-flag set has become empty and then non-empty again.
- R9: A `reti_i` pulse gives `pop_o` and `pc_load_o` in the next cycle, with `pc_load_addr_o` equal to `stack_top_i` from the pulse cycle. It also sets the global enable to 1, so a source that is still pending is taken one cycle later.
- R10: If a comparator event and a register-0 write that clears the same flag come in the same cycle, the flag ends up set.
- R11: Taking a direct source clears its pending flag, so after return it is not taken again without a new event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_cmp_i | input | 3 | Comparator match pulses: bit 0 P, bit 1 A, bit 2 B |
| evt_dir_i | input | N_DIR | Event pulses of the directly vectored sources |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | 0 = comparator flag/enable register, 1 = global enable register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| pc_i | input | PC_W | Core's current program counter |
| reti_i | input | 1 | Return-from-interrupt strobe |
| stack_top_i | input | PC_W | Program counter on top of the core's return stack |
| push_o | output | 1 | Push the captured program counter |
| push_pc_o | output | PC_W | Program counter to push |
| pop_o | output | 1 | Pop the return stack |
| pc_load_o | output | 1 | Load `pc_load_addr_o` into the program counter |
| pc_load_addr_o | output | PC_W | Vector address, or the restored return address |

## Verification
The assertions assume that `reti_i` comes only inside a handler, so that it never coincides with a take decision. They also assume the global enable is not rewritten in the same cycle as a return. They read each event and strobe input as a single-cycle pulse. The stimulus raises every strobe for exactly one cycle and issues returns only after a take has been seen. Global-enable writes are always placed in cycles of their own, apart from any return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int GRP_N    = 3;
  localparam int FLAG_LSB = 4;
  localparam int EN_LSB   = 0;
  localparam int GIE_BIT  = 0;

  typedef enum logic {
    REG_CMP = 1'b0,
    REG_GIE = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic [GRP_N-1:0] flag;
    logic [GRP_N-1:0] en;
  } cmp_state_t;
endpackage

// File: rtl/irq_cmp_group.sv
module irq_cmp_group
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_N-1:0] evt_i,
  input  logic             wr_i,
  input  logic [GRP_N-1:0] wflag_i,
  input  logic [GRP_N-1:0] wen_i,
  input  logic             take_i,
  output cmp_state_t       st_o,
  output logic             pend_o
);
  cmp_state_t st_q, st_d;
  logic       pend_q;
  logic       req_now, req_nxt;

  always_comb begin
    st_d = st_q;
    if (wr_i) begin
      st_d.flag = wflag_i;
      st_d.en   = wen_i;
    end
    // a hardware event wins over a software clear in the same cycle
    st_d.flag = st_d.flag | evt_i;
  end

  assign req_now = |(st_q.flag & st_q.en);
  assign req_nxt = |(st_d.flag & st_d.en);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (req_nxt && !req_now) pend_q <= 1'b1;
      else if (take_i)         pend_q <= 1'b0;
    end
  end

  assign st_o   = st_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/irq_direct_flags.sv
module irq_direct_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic f_q;
    always_ff @(posedge clk) begin
      if (rst)           f_q <= 1'b0;
      else if (evt_i[i]) f_q <= 1'b1;
      else if (clr_i[i]) f_q <= 1'b0;
    end
    assign flag_o[i] = f_q;
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N        = 3,
  parameter int PC_W     = 12,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [N-1:0]    req_i,
  output logic [N-1:0]    gnt_o,
  output logic            any_o,
  output logic [PC_W-1:0] vec_o
);
  always_comb begin
    gnt_o = '0;
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        vec_o    = PC_W'(VEC_BASE + i * VEC_STEP);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int PC_W     = 12,
  parameter int N_DIR    = 2,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       evt_cmp_i,
  input  logic [N_DIR-1:0] evt_dir_i,
  input  logic             reg_we_i,
  input  logic             reg_re_i,
  input  logic             reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [7:0]       reg_rdata_o,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             reti_i,
  input  logic [PC_W-1:0]  stack_top_i,
  output logic             push_o,
  output logic [PC_W-1:0]  push_pc_o,
  output logic             pop_o,
  output logic             pc_load_o,
  output logic [PC_W-1:0]  pc_load_addr_o
);
  localparam int N_SRC = N_DIR + 1;
  localparam int GRP_IDX = N_DIR;

  logic              gie_q;
  logic [N_DIR-1:0]  dir_flag;
  logic [N_SRC-1:0]  req, gnt;
  logic              any_req, take;
  logic [PC_W-1:0]   vec;
  cmp_state_t        cmp_st;
  logic              grp_pend;
  logic              wr_cmp, wr_gie;
  logic              unused_wbits;

  assign wr_cmp = reg_we_i && (reg_addr_i == REG_CMP);
  assign wr_gie = reg_we_i && (reg_addr_i == REG_GIE);
  assign unused_wbits = ^{reg_wdata_i[7], reg_wdata_i[3]};

  irq_cmp_group u_grp (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt_cmp_i),
    .wr_i    (wr_cmp),
    .wflag_i (reg_wdata_i[FLAG_LSB +: GRP_N]),
    .wen_i   (reg_wdata_i[EN_LSB +: GRP_N]),
    .take_i  (take && gnt[GRP_IDX]),
    .st_o    (cmp_st),
    .pend_o  (grp_pend)
  );

  irq_direct_flags #(.N(N_DIR)) u_dir (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (evt_dir_i),
    .clr_i  (take ? gnt[N_DIR-1:0] : '0),
    .flag_o (dir_flag)
  );

  assign req = {grp_pend, dir_flag};

  irq_prio_sel #(
    .N(N_SRC), .PC_W(PC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_sel (
    .req_i (req),
    .gnt_o (gnt),
    .any_o (any_req),
    .vec_o (vec)
  );

  assign take = gie_q && any_req && !reti_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q          <= 1'b0;
      push_o         <= 1'b0;
      push_pc_o      <= '0;
      pop_o          <= 1'b0;
      pc_load_o      <= 1'b0;
      pc_load_addr_o <= '0;
      reg_rdata_o    <= '0;
    end else begin
      if (reti_i)      gie_q <= 1'b1;
      else if (take)   gie_q <= 1'b0;
      else if (wr_gie) gie_q <= reg_wdata_i[GIE_BIT];

      push_o    <= take;
      pop_o     <= reti_i;
      pc_load_o <= take || reti_i;
      if (take) push_pc_o <= pc_i;
      if (reti_i)    pc_load_addr_o <= stack_top_i;
      else if (take) pc_load_addr_o <= vec;

      if (reg_re_i) begin
        if (reg_addr_i == REG_CMP)
          reg_rdata_o <= {1'b0, cmp_st.flag, 1'b0, cmp_st.en};
        else
          reg_rdata_o <= {7'b0, gie_q};
      end
    end
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int PC_W  = 12,
  parameter int N_SRC = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             gie,
  input logic [N_SRC-1:0] gnt,
  input logic             reti_i,
  input logic [PC_W-1:0]  stack_top_i,
  input logic [7:0]       reg_rdata_o,
  input logic             push_o,
  input logic             pop_o,
  input logic             pc_load_o,
  input logic [PC_W-1:0]  pc_load_addr_o
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    !reg_rdata_o[7] && !reg_rdata_o[3]); // R2
  AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!gie && !reti_i) |=> !push_o); // R4
  AST_PUSH_LOADS: assert property (@(posedge clk) disable iff (rst)
    push_o |-> (pc_load_o && !pop_o)); // R5
  AST_NO_NEST: assert property (@(posedge clk) disable iff (rst)
    push_o |-> !gie); // R6
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    push_o |=> !push_o); // R6
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt)); // R7
  AST_RETI_RESTORE: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> (pop_o && pc_load_o && pc_load_addr_o == $past(stack_top_i))); // R9
  AST_RETI_REENABLE: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> gie); // R9
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.PC_W(PC_W), .N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .gie(gie_q), .gnt(gnt), .reti_i(reti_i),
  .stack_top_i(stack_top_i), .reg_rdata_o(reg_rdata_o), .push_o(push_o),
  .pop_o(pop_o), .pc_load_o(pc_load_o), .pc_load_addr_o(pc_load_addr_o)
);

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 12;
  localparam int N_DIR = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] evt_cmp_i = '0;
  logic [N_DIR-1:0] evt_dir_i = '0;
  logic reg_we_i = 1'b0, reg_re_i = 1'b0, reg_addr_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic [PC_W-1:0] pc_i = 12'h123;
  logic reti_i = 1'b0;
  logic [PC_W-1:0] stack_top_i = '0;
  logic push_o, pop_o, pc_load_o;
  logic [PC_W-1:0] push_pc_o, pc_load_addr_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst(rst), .evt_cmp_i(evt_cmp_i), .evt_dir_i(evt_dir_i),
    .reg_we_i(reg_we_i), .reg_re_i(reg_re_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .pc_i(pc_i),
    .reti_i(reti_i), .stack_top_i(stack_top_i), .push_o(push_o),
    .push_pc_o(push_pc_o), .pop_o(pop_o), .pc_load_o(pc_load_o),
    .pc_load_addr_o(pc_load_addr_o)
  );

  // behavioural reference model
  bit m_flag[3], m_en[3], m_dir[N_DIR];
  bit m_gie, m_grp, m_push, m_pop, m_load;
  int m_pushpc, m_addr, m_rdata;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_flag[i]) begin m_flag[i] = 0; m_en[i] = 0; end
      foreach (m_dir[i]) m_dir[i] = 0;
      m_gie = 0; m_grp = 0; m_push = 0; m_pop = 0; m_load = 0;
      m_pushpc = 0; m_addr = 0; m_rdata = 0;
    end else begin
      int sel; bit take; bit any; bit nf[3]; bit ne[3]; bit rq_now, rq_nxt;
      sel = -1;
      for (int i = 0; i < N_DIR; i++) if (sel < 0 && m_dir[i]) sel = i;
      if (sel < 0 && m_grp) sel = N_DIR;
      any = (sel >= 0);
      take = m_gie && any && !reti_i;
      rq_now = 0; rq_nxt = 0;
      for (int i = 0; i < 3; i++) begin
        nf[i] = m_flag[i]; ne[i] = m_en[i];
        if (reg_we_i && !reg_addr_i) begin nf[i] = reg_wdata_i[4+i]; ne[i] = reg_wdata_i[i]; end
        if (evt_cmp_i[i]) nf[i] = 1;
        rq_now |= m_flag[i] & m_en[i];
        rq_nxt |= nf[i] & ne[i];
      end
      if (reg_re_i)
        m_rdata = reg_addr_i ? int'(m_gie)
                : ((m_flag[2] << 6) | (m_flag[1] << 5) | (m_flag[0] << 4) |
                   (m_en[2] << 2) | (m_en[1] << 1) | int'(m_en[0]));
      m_push = take; m_pop = reti_i; m_load = take || reti_i;
      if (take) m_pushpc = int'(pc_i);
      if (reti_i) m_addr = int'(stack_top_i);
      else if (take) m_addr = 4 + sel * 4;
      if (rq_nxt && !rq_now) m_grp = 1;
      else if (take && sel == N_DIR) m_grp = 0;
      for (int i = 0; i < N_DIR; i++) begin
        if (evt_dir_i[i]) m_dir[i] = 1;
        else if (take && sel == i) m_dir[i] = 0;
      end
      if (reti_i) m_gie = 1;
      else if (take) m_gie = 0;
      else if (reg_we_i && reg_addr_i) m_gie = reg_wdata_i[0];
      for (int i = 0; i < 3; i++) begin m_flag[i] = nf[i]; m_en[i] = ne[i]; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model comparison on every cycle
  always @(negedge clk) if (!rst && !done) begin
    chk(push_o == m_push, {cur_req, " push"}, int'(push_o), int'(m_push));
    chk(pop_o == m_pop, {cur_req, " pop"}, int'(pop_o), int'(m_pop));
    chk(pc_load_o == m_load, {cur_req, " load"}, int'(pc_load_o), int'(m_load));
    chk(int'(pc_load_addr_o) == m_addr, {cur_req, " addr"}, int'(pc_load_addr_o), m_addr);
    chk(int'(push_pc_o) == m_pushpc, {cur_req, " pushpc"}, int'(push_pc_o), m_pushpc);
    chk(int'(reg_rdata_o) == m_rdata, {cur_req, " rdata"}, int'(reg_rdata_o), m_rdata);
  end

  task automatic wr(input bit a, input logic [7:0] d);
    reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk); reg_we_i = 0;
  endtask
  task automatic rd(input bit a);
    reg_re_i = 1; reg_addr_i = a;
    @(negedge clk); reg_re_i = 0;
  endtask
  task automatic ecmp(input logic [2:0] b);
    evt_cmp_i = b; @(negedge clk); evt_cmp_i = '0;
  endtask
  task automatic edir(input logic [N_DIR-1:0] b);
    evt_dir_i = b; @(negedge clk); evt_dir_i = '0;
  endtask
  task automatic ret(input logic [PC_W-1:0] t);
    reti_i = 1; stack_top_i = t; @(negedge clk); reti_i = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    cur_req = "R2";
    rd(0); chk(reg_rdata_o == 8'h00, "R2 reset cmp reg", reg_rdata_o, 0);
    rd(1); chk(reg_rdata_o == 8'h00, "R2 reset gie", reg_rdata_o, 0);
    wr(0, 8'h8F); rd(0); chk(reg_rdata_o == 8'h07, "R2 reserved bits", reg_rdata_o, 8'h07);

    cur_req = "R4";
    ecmp(3'b001); idle(3);
    chk(push_o == 0, "R4 gie off blocks", push_o, 0);
    rd(0); chk(reg_rdata_o == 8'h17, "R1 flag P bit4", reg_rdata_o, 8'h17);

    cur_req = "R5";
    pc_i = 12'h2A0;
    wr(1, 8'h01); @(negedge clk);
    chk(push_o && pc_load_o, "R5 take strobe", push_o, 1);
    chk(pc_load_addr_o == 12'h00C, "R5 group vector", pc_load_addr_o, 12'h00C);
    chk(push_pc_o == 12'h2A0, "R5 pushed pc", push_pc_o, 12'h2A0);

    cur_req = "R6";
    rd(1); chk(reg_rdata_o == 8'h00, "R6 gie cleared on take", reg_rdata_o, 0);
    edir(2'b01); idle(2);
    chk(push_o == 0, "R6 no nesting", push_o, 0);

    cur_req = "R9";
    ret(12'h055);
    chk(pop_o && pc_load_addr_o == 12'h055, "R9 restore", pc_load_addr_o, 12'h055);
    @(negedge clk);
    chk(push_o && pc_load_addr_o == 12'h004, "R9 pending taken after return", pc_load_addr_o, 12'h004);

    cur_req = "R8";
    ret(12'h066); idle(3);
    chk(push_o == 0, "R8 R11 no re-take without re-arm", push_o, 0);
    rd(0); chk(reg_rdata_o == 8'h17, "R8 sub-flag kept", reg_rdata_o, 8'h17);

    cur_req = "R7";
    wr(1, 8'h00); wr(0, 8'h07);
    evt_dir_i = 2'b11; evt_cmp_i = 3'b100; @(negedge clk);
    evt_dir_i = '0; evt_cmp_i = '0;
    wr(1, 8'h01); @(negedge clk);
    chk(pc_load_addr_o == 12'h004, "R7 direct0 first", pc_load_addr_o, 12'h004);
    ret(12'h100); @(negedge clk);
    chk(pc_load_addr_o == 12'h008, "R7 direct1 second", pc_load_addr_o, 12'h008);
    ret(12'h101); @(negedge clk);
    chk(pc_load_addr_o == 12'h00C, "R7 group last", pc_load_addr_o, 12'h00C);

    cur_req = "R3";
    ret(12'h102); wr(0, 8'h00);
    ecmp(3'b100); idle(3);
    chk(push_o == 0, "R3 disabled flag no jump", push_o, 0);
    rd(0); chk(reg_rdata_o == 8'h40, "R3 flag latched", reg_rdata_o, 8'h40);
    wr(0, 8'h44); @(negedge clk);
    chk(push_o && pc_load_addr_o == 12'h00C, "R3 enable later jumps", pc_load_addr_o, 12'h00C);

    cur_req = "R10";
    ret(12'h103);
    reg_we_i = 1; reg_addr_i = 0; reg_wdata_i = 8'h00; evt_cmp_i = 3'b010;
    @(negedge clk); reg_we_i = 0; evt_cmp_i = '0;
    rd(0); chk(reg_rdata_o == 8'h20, "R10 event beats clear", reg_rdata_o, 8'h20);
    idle(2);
    chk(push_o == 0, "R10 R11 quiet", push_o, 0);

    idle(2);
    finish_run();
  end
endmodule